// File: doc/BRIEF.md
# Core Sleep Request Handshake

This block sits between the wait-for-interrupt indications of two application cores and a shared L2 cache and the per-core power-down request lines of a power controller. All of these inputs arrive from other clock domains. Each one passes through a synchronizer before the block uses it. The synchronized wait-for-interrupt levels form a 32-bit read-only status word. Each core's sleep output gives a single one-cycle pulse when that core both asks to power down and is sitting in wait-for-interrupt. The pulse fires on the cycle the pair of conditions first becomes true, not on every cycle it stays true.

The block also holds two 32-bit power-state words: a local one and an auxiliary one. Every bit of each word drives an output line. Either word can be written through a simple write strobe, and the target word is picked by a select bit. Some bits of each word cannot be changed and always keep their reset value. The low four bits of the local word also drive four power-down status lines, which carry the inverse of those bits.

Top module: `core_sleep_hs`

## Requirements
- R1: While reset is asserted, the outputs take these values: status word 0x00010003, local state 0x00FFFD87, auxiliary state 0x000FF080, sleep pulses 0, power-down status 0x8.
- R2: The status word holds the core 0 wait-for-interrupt input in bit 0, the core 1 input in bit 1 and the L2 input in bit 16. All other status bits read 0. An input change appears in the status word after the second rising clock edge and not before.
- R3: The four power-down request inputs are levels. Each is synchronized through two flops, and a request counts for as long as it is held.
- R4: Sleep pulse i goes high for exactly one cycle when synchronized request i and status bit i are both 1. It is visible after the third rising edge after the later of the two inputs was applied. Because status bits 2 and 3 are always 0, requests 2 and 3 never pulse.
- R5: A condition that stays true does not pulse again. Once the condition drops, a fresh rise (of either the request or the wait-for-interrupt input) gives a new pulse.
- R6: A write with select 0 updates the local state on the next edge. Bits in the fixed mask 0xFF80037C keep their reset value, and all other bits take the written data.
- R7: A write with select 1 updates the auxiliary state on the next edge. Bits in the fixed mask 0xC7F00F7F keep their reset value, and all other bits take the written data.
- R8: A write to one state word leaves the other word unchanged. With the write strobe low, neither word changes.
- R9: Power-down status bit i equals the inverse of local state bit i for i from 0 to 3. It changes in the same cycle as the state bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_core_i | input | 2 | Per-core wait-for-interrupt levels (asynchronous) |
| wfi_l2_i | input | 1 | L2 cache wait-for-interrupt level (asynchronous) |
| pdreq_i | input | 4 | Per-core power-down request levels (asynchronous) |
| wr_en_i | input | 1 | Write strobe for a state word |
| wr_sel_i | input | 1 | Write target: 0 local state, 1 auxiliary state |
| wr_data_i | input | 32 | Write data |
| wfi_status_o | output | 32 | Synchronized wait-for-interrupt status word |
| sleep_o | output | 4 | One-cycle sleep pulses, one per request index |
| pwr_state_o | output | 32 | Local power-state word, one line per bit |
| aux_state_o | output | 32 | Auxiliary power-state word, one line per bit |
| pdn_stat_o | output | 4 | Inverted low four bits of the local state |

## Verification
If a synchronizer stage is lost or its reset value is wrong, the status word moves one edge early or comes out of reset at the wrong value. Either fault is visible at the ports within two cycles of the stimulus. If the edge-detect flop that remembers the previous condition is corrupted, the fault shows on the next cycle as a missing pulse, a pulse that stays high two cycles, or a pulse repeated while the condition is held. If the keep-mask of a state word is wrong, the next write shows it at once, as a fixed bit that flips or a writable bit that sticks. The power-down status lines expose the low local bits in the same cycle.

// File: rtl/chs_pkg.sv
package chs_pkg;
    localparam int WORD_W = 32;

    typedef enum logic {
        TGT_LOCAL = 1'b0,
        TGT_AUX   = 1'b1
    } wr_tgt_e;

    localparam logic [WORD_W-1:0] LOCAL_RST  = 32'h00FF_FD87;
    localparam logic [WORD_W-1:0] LOCAL_KEEP = 32'hFF80_037C;
    localparam logic [WORD_W-1:0] AUX_RST    = 32'h000F_F080;
    localparam logic [WORD_W-1:0] AUX_KEEP   = 32'hC7F0_0F7F;
    localparam int                L2_BIT     = 16;
endpackage

// File: rtl/chs_sync.sv
module chs_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_V}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/chs_state_reg.sv
module chs_state_reg #(
    parameter int           W     = 32,
    parameter logic [W-1:0] RST_V = '0,
    parameter logic [W-1:0] KEEP  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = (wr_data & ~KEEP) | (word_q & KEEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= RST_V;
        end else begin
            word_q <= word_d;
        end
    end

    assign q = word_q;
endmodule

// File: rtl/chs_sleep_gen.sv
module chs_sleep_gen #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] wfi,
    output logic [N-1:0] pulse
);
    typedef struct packed {
        logic [N-1:0] cond;
        logic [N-1:0] pulse;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d.cond  = req & wfi;
        st_d.pulse = st_d.cond & ~st_q.cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/core_sleep_hs.sv
module core_sleep_hs #(
    parameter int N_CORE      = 2,
    parameter int N_REQ       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORE-1:0]          wfi_core_i,
    input  logic                       wfi_l2_i,
    input  logic [N_REQ-1:0]           pdreq_i,
    input  logic                       wr_en_i,
    input  logic                       wr_sel_i,
    input  logic [chs_pkg::WORD_W-1:0] wr_data_i,
    output logic [chs_pkg::WORD_W-1:0] wfi_status_o,
    output logic [N_REQ-1:0]           sleep_o,
    output logic [chs_pkg::WORD_W-1:0] pwr_state_o,
    output logic [chs_pkg::WORD_W-1:0] aux_state_o,
    output logic [N_REQ-1:0]           pdn_stat_o
);
    import chs_pkg::*;

    localparam int WFI_W = N_CORE + 1;

    logic [WFI_W-1:0]  wfi_s;
    logic [N_REQ-1:0]  req_s;
    logic [WORD_W-1:0] status_w;
    logic              wr_local, wr_aux;

    chs_sync #(.W(WFI_W), .STAGES(SYNC_STAGES), .RST_V({WFI_W{1'b1}})) u_wfi_sync (
        .clk(clk), .rst_n(rst_n), .din({wfi_l2_i, wfi_core_i}), .dout(wfi_s)
    );

    chs_sync #(.W(N_REQ), .STAGES(SYNC_STAGES), .RST_V('0)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .din(pdreq_i), .dout(req_s)
    );

    always_comb begin
        status_w = '0;
        for (int c = 0; c < N_CORE; c++) begin
            status_w[c] = wfi_s[c];
        end
        status_w[L2_BIT] = wfi_s[N_CORE];
    end

    chs_sleep_gen #(.N(N_REQ)) u_sleep (
        .clk(clk), .rst_n(rst_n), .req(req_s), .wfi(status_w[N_REQ-1:0]), .pulse(sleep_o)
    );

    assign wr_local = wr_en_i && (wr_tgt_e'(wr_sel_i) == TGT_LOCAL);
    assign wr_aux   = wr_en_i && (wr_tgt_e'(wr_sel_i) == TGT_AUX);

    chs_state_reg #(.W(WORD_W), .RST_V(LOCAL_RST), .KEEP(LOCAL_KEEP)) u_local (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_local), .wr_data(wr_data_i), .q(pwr_state_o)
    );

    chs_state_reg #(.W(WORD_W), .RST_V(AUX_RST), .KEEP(AUX_KEEP)) u_aux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_aux), .wr_data(wr_data_i), .q(aux_state_o)
    );

    assign wfi_status_o = status_w;
    assign pdn_stat_o   = ~pwr_state_o[N_REQ-1:0];
endmodule

// File: rtl/core_sleep_hs_chk.sv
module core_sleep_hs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic        wr_sel_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] wfi_status_o,
    input logic [3:0]  sleep_o,
    input logic [31:0] pwr_state_o,
    input logic [31:0] aux_state_o
);
    import chs_pkg::*;

    assert_single_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o != 4'b0) |=> ((sleep_o & $past(sleep_o)) == 4'b0));

    assert_pulse_needs_wfi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o != 4'b0) |-> ((sleep_o & ~$past(wfi_status_o[3:0])) == 4'b0));

    assert_local_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> ((pwr_state_o & ~LOCAL_KEEP) == ($past(wr_data_i) & ~LOCAL_KEEP)));

    assert_local_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o & LOCAL_KEEP) == (LOCAL_RST & LOCAL_KEEP));

    assert_aux_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_state_o & AUX_KEEP) == (AUX_RST & AUX_KEEP));

    assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(pwr_state_o) && $stable(aux_state_o)));

    assert_aux_write_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> $stable(pwr_state_o));
endmodule

bind core_sleep_hs core_sleep_hs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .wfi_status_o(wfi_status_o), .sleep_o(sleep_o),
    .pwr_state_o(pwr_state_o), .aux_state_o(aux_state_o)
);

// File: tb/core_sleep_hs_bench.sv
`timescale 1ns/1ps
module core_sleep_hs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wfi_core = 2'b00;
    logic        wfi_l2 = 1'b0;
    logic [3:0]  pdreq = 4'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wfi_status, pwr_state, aux_state;
    logic [3:0]  sleep, pdn_stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] L_RST  = 32'h00FF_FD87;
    localparam logic [31:0] L_KEEP = 32'hFF80_037C;
    localparam logic [31:0] A_RST  = 32'h000F_F080;
    localparam logic [31:0] A_KEEP = 32'hC7F0_0F7F;

    always #2 clk = ~clk;

    core_sleep_hs u_core_sleep_hs (
        .clk(clk), .rst_n(rst_n), .wfi_core_i(wfi_core), .wfi_l2_i(wfi_l2),
        .pdreq_i(pdreq), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .wfi_status_o(wfi_status), .sleep_o(sleep), .pwr_state_o(pwr_state),
        .aux_state_o(aux_state), .pdn_stat_o(pdn_stat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic watch_pulse(input string tag, input logic [3:0] exp);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check(tag, {28'b0, sleep}, (k == 3) ? {28'b0, exp} : 32'b0);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_write(input logic sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        #7;
        check("R1 status", wfi_status, 32'h0001_0003);
        check("R1 local", pwr_state, L_RST);
        check("R1 aux", aux_state, A_RST);
        check("R1 sleep", {28'b0, sleep}, 32'b0);
        check("R1 pdn", {28'b0, pdn_stat}, 32'h8);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
    endtask

    task automatic t_wfi_map();
        check("R2 cleared", wfi_status, 32'h0);
        wfi_core = 2'b01; wfi_l2 = 1'b1;
        @(negedge clk);
        check("R2 one edge", wfi_status, 32'h0);
        @(negedge clk);
        check("R2 core0+l2", wfi_status, 32'h0001_0001);
        wfi_core = 2'b10; wfi_l2 = 1'b0;
        idle(2);
        check("R2 core1", wfi_status, 32'h0000_0002);
        wfi_core = 2'b11; wfi_l2 = 1'b1;
        idle(3);
    endtask

    task automatic t_sleep_basic();
        pdreq = 4'b0001;
        watch_pulse("R4 core0 pulse", 4'b0001);
        idle(4);
        check("R5 held no repulse", {28'b0, sleep}, 32'b0);
        pdreq = 4'b0000;
        idle(4);
        pdreq = 4'b0011;
        watch_pulse("R3 R4 both cores", 4'b0011);
        pdreq = 4'b1111;
        watch_pulse("R4 idx2 idx3 silent", 4'b0000);
        pdreq = 4'b0000;
        idle(4);
    endtask

    task automatic t_sleep_order();
        wfi_core = 2'b00;
        pdreq = 4'b0010;
        idle(4);
        check("R3 req alone", {28'b0, sleep}, 32'b0);
        wfi_core = 2'b10;
        watch_pulse("R4 wfi after req", 4'b0010);
        wfi_core = 2'b00;
        idle(4);
        wfi_core = 2'b10;
        watch_pulse("R5 wfi re-rise", 4'b0010);
        pdreq = 4'b0000;
        wfi_core = 2'b11;
        idle(4);
    endtask

    task automatic t_writes();
        do_write(1'b0, 32'hFFFF_FFFF);
        check("R6 local ones", pwr_state, (32'hFFFF_FFFF & ~L_KEEP) | (L_RST & L_KEEP));
        check("R8 aux untouched", aux_state, A_RST);
        check("R9 pdn ones", {28'b0, pdn_stat}, {28'b0, ~pwr_state[3:0]});
        do_write(1'b0, 32'h0000_0000);
        check("R6 local zero", pwr_state, L_RST & L_KEEP);
        check("R9 pdn zero", {28'b0, pdn_stat}, 32'hB);
        do_write(1'b1, 32'hFFFF_FFFF);
        check("R7 aux ones", aux_state, (32'hFFFF_FFFF & ~A_KEEP) | (A_RST & A_KEEP));
        check("R8 local untouched", pwr_state, L_RST & L_KEEP);
        do_write(1'b1, 32'h0000_0000);
        check("R7 aux zero", aux_state, A_RST & A_KEEP);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 32'h0000_0005;
        idle(2);
        check("R8 no strobe", pwr_state, L_RST & L_KEEP);
        do_write(1'b0, 32'h0000_0005);
        check("R9 pdn pattern", {28'b0, pdn_stat}, 32'hA);
        check("R6 pattern", pwr_state, (32'h5 & ~L_KEEP) | (L_RST & L_KEEP));
    endtask

    initial begin
        t_reset();
        t_wfi_map();
        t_sleep_basic();
        t_sleep_order();
        t_writes();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule